// File: doc/BRIEF.md
# Stereo-Mono Blend Controller

This block sits behind an FM stereo decoder. Each audio sample period it receives one sum sample (L+R) and one difference sample (L-R), together with three signal-quality figures: signal strength, SNR and a multipath quality figure. Each quality figure is compared against its own pair of programmable thresholds. The poorest of the three resulting targets becomes the blend target.

An 8-bit blend factor chases that target at a programmable, rate-limited speed. The difference sample is scaled by the blend factor before left and right are rebuilt, so poor reception slides the output smoothly toward mono instead of switching abruptly. A separate stereo indicator flag, intended for a display, is derived from the separation estimate and the signal strength. One of two criteria applies, picked by a select input.

All thresholds and rates are plain inputs driven by configuration registers elsewhere in the chip. A suitable reset setting for the signal-strength pair is a stereo threshold of 49 and a mono threshold of 8. The block advances only on a one-cycle update strobe.

Top module: `stereo_blend_ctrl`

## Requirements
- R1: While reset is asserted, and on release, the blend factor is 0 (full mono), both audio outputs are 0 and the stereo indicator is low.
- R2: On each update strobe the outputs load left = sum + D and right = sum - D. Here D equals the difference sample when the blend factor (the value held before that strobe) is 255. Otherwise D is floor(difference * blend / 256).
- R3: Left and right saturate at the signed audio word limits (+32767 / -32768 for 16 bits) instead of wrapping.
- R4: A quality figure below its mono threshold gives a per-figure target of 0.
- R5: A quality figure at or above its stereo threshold gives a per-figure target of 255. When all three figures do so, the blend target is 255.
- R6: A figure m with mono <= m < stereo gives the target floor((m - mono) * 255 / (stereo - mono)). The blend target is the minimum of the three per-figure targets.
- R7: A stereo threshold of 0 forces that figure's target to 255. A mono threshold of 127 (all ones) forces it to 0, and this takes priority over the stereo override.
- R8: On each strobe the blend factor moves toward the target and never passes it. When moving down, it moves by at most the attack rate of the governing figure; when moving up, by at most that figure's release rate. The governing figure is the one with the lowest target, and ties go to signal strength, then SNR, then multipath. A rate of 0 holds the factor.
- R9: Without an update strobe, the blend factor, the audio outputs and the indicator keep their values whatever the other inputs do.
- R10: On each strobe the indicator loads 1 in one of two cases, and 0 otherwise. With select = 0: separation > 6 and signal strength > 20. With select = 1: separation > 12 and signal strength > 28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle update strobe per sample period |
| sum_i | input | 16 | Signed sum (L+R) sample |
| diff_i | input | 16 | Signed difference (L-R) sample |
| rssi_i | input | 7 | Signal strength figure, dB |
| snr_i | input | 7 | SNR figure, dB |
| mpath_i | input | 7 | Multipath quality figure, higher is cleaner |
| sep_i | input | 7 | Channel separation estimate, dB |
| rssi_mono_th_i | input | 7 | Signal strength mono threshold |
| rssi_st_th_i | input | 7 | Signal strength stereo threshold |
| snr_mono_th_i | input | 7 | SNR mono threshold |
| snr_st_th_i | input | 7 | SNR stereo threshold |
| mpath_mono_th_i | input | 7 | Multipath mono threshold |
| mpath_st_th_i | input | 7 | Multipath stereo threshold |
| rssi_att_i | input | 8 | Signal strength attack step |
| rssi_rel_i | input | 8 | Signal strength release step |
| snr_att_i | input | 8 | SNR attack step |
| snr_rel_i | input | 8 | SNR release step |
| mpath_att_i | input | 8 | Multipath attack step |
| mpath_rel_i | input | 8 | Multipath release step |
| ind_sel_i | input | 1 | Indicator criterion select |
| left_o | output | 16 | Left audio sample |
| right_o | output | 16 | Right audio sample |
| blend_o | output | 8 | Blend factor, 0 mono, 255 stereo |
| stereo_ind_o | output | 1 | Stereo indicator flag |

## Verification
The blend factor is the only long-lived state, and it appears directly on `blend_o` one cycle after each strobe. A wrong step size, a wrong governing figure or an overshoot shows at once in the sequence of values the bench predicts strobe by strobe. A corrupted factor also shows in the next strobe's left/right pair, because that pair is built from the factor held before the strobe. Gating faults appear as outputs that change during strobe-free intervals.

// File: rtl/blend_pkg.sv
package blend_pkg;
  localparam int unsigned N_MET = 3;
  typedef enum logic [1:0] {MET_RSSI = 2'd0, MET_SNR = 2'd1, MET_MPATH = 2'd2} met_e;
  localparam int unsigned IND_SEP_LO  = 6;
  localparam int unsigned IND_RSSI_LO = 20;
  localparam int unsigned IND_SEP_HI  = 12;
  localparam int unsigned IND_RSSI_HI = 28;
endpackage

// File: rtl/blend_target.sv
module blend_target #(
  parameter int unsigned MW = 7,
  parameter int unsigned BW = 8
) (
  input  logic [MW-1:0] metric_i,
  input  logic [MW-1:0] mono_th_i,
  input  logic [MW-1:0] st_th_i,
  output logic [BW-1:0] target_o
);
  localparam int unsigned PW = MW + BW;
  localparam logic [MW-1:0] MMAX = {MW{1'b1}};
  localparam logic [BW-1:0] BMAX = {BW{1'b1}};

  logic [MW-1:0] pos, span;
  logic [PW-1:0] prod, quo;

  always_comb begin
    pos  = metric_i - mono_th_i;
    span = st_th_i - mono_th_i;
    prod = PW'(pos) * PW'(BMAX);
    quo  = (span != '0) ? (prod / PW'(span)) : '0;
    if (mono_th_i == MMAX)           target_o = '0;
    else if (st_th_i == '0)          target_o = BMAX;
    else if (metric_i < mono_th_i)   target_o = '0;
    else if (metric_i >= st_th_i)    target_o = BMAX;
    else if (quo > PW'(BMAX))        target_o = BMAX;
    else                             target_o = quo[BW-1:0];
  end
endmodule

// File: rtl/blend_slew.sv
module blend_slew #(
  parameter int unsigned N  = 3,
  parameter int unsigned BW = 8,
  parameter int unsigned RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic [BW-1:0] tgt_i [N],
  input  logic [RW-1:0] att_i [N],
  input  logic [RW-1:0] rel_i [N],
  output logic [BW-1:0] tgt_min_o,
  output logic [BW-1:0] blend_o
);
  localparam int unsigned SW = (RW > BW) ? RW : BW;

  logic [BW-1:0] blend_q, blend_d, best;
  logic [RW-1:0] best_att, best_rel;
  logic [SW-1:0] gap, step;

  always_comb begin
    best     = tgt_i[0];
    best_att = att_i[0];
    best_rel = rel_i[0];
    for (int i = 1; i < int'(N); i++) begin
      if (tgt_i[i] < best) begin
        best     = tgt_i[i];
        best_att = att_i[i];
        best_rel = rel_i[i];
      end
    end
  end

  always_comb begin
    blend_d = blend_q;
    gap     = '0;
    step    = '0;
    if (tick_i) begin
      if (blend_q > best) begin
        gap  = SW'(blend_q) - SW'(best);
        step = SW'(best_att);
        blend_d = (step >= gap) ? best : BW'(SW'(blend_q) - step);
      end else begin
        gap  = SW'(best) - SW'(blend_q);
        step = SW'(best_rel);
        blend_d = (step >= gap) ? best : BW'(SW'(blend_q) + step);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blend_q <= '0;
    else        blend_q <= blend_d;
  end

  assign tgt_min_o = best;
  assign blend_o   = blend_q;
endmodule

// File: rtl/audio_matrix.sv
module audio_matrix #(
  parameter int unsigned AW = 16,
  parameter int unsigned BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic [BW-1:0] blend_i,
  input  logic [AW-1:0] sum_i,
  input  logic [AW-1:0] diff_i,
  output logic [AW-1:0] left_o,
  output logic [AW-1:0] right_o
);
  localparam int unsigned XW = AW + BW + 1;
  localparam logic [BW-1:0] BMAX = {BW{1'b1}};
  localparam logic signed [XW-1:0] AMAX = XW'((64'sd1 <<< (AW - 1)) - 1);
  localparam logic signed [XW-1:0] AMIN = -AMAX - 1;

  logic signed [XW-1:0] prod, scaled, sum_x, l_x, r_x;
  logic [AW-1:0] left_d, right_d, left_q, right_q;

  function automatic logic [AW-1:0] clip(input logic signed [XW-1:0] v);
    if (v > AMAX)      return AMAX[AW-1:0];
    else if (v < AMIN) return AMIN[AW-1:0];
    else               return v[AW-1:0];
  endfunction

  always_comb begin
    prod   = XW'($signed(diff_i)) * $signed({1'b0, blend_i});
    scaled = (blend_i == BMAX) ? XW'($signed(diff_i)) : (prod >>> BW);
    sum_x  = XW'($signed(sum_i));
    l_x    = sum_x + scaled;
    r_x    = sum_x - scaled;
    left_d  = tick_i ? clip(l_x) : left_q;
    right_d = tick_i ? clip(r_x) : right_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      right_q <= '0;
    end else begin
      left_q  <= left_d;
      right_q <= right_d;
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
endmodule

// File: rtl/stereo_blend_ctrl.sv
module stereo_blend_ctrl #(
  parameter int unsigned AW = 16,
  parameter int unsigned MW = 7,
  parameter int unsigned BW = 8,
  parameter int unsigned RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic [AW-1:0] sum_i,
  input  logic [AW-1:0] diff_i,
  input  logic [MW-1:0] rssi_i,
  input  logic [MW-1:0] snr_i,
  input  logic [MW-1:0] mpath_i,
  input  logic [MW-1:0] sep_i,
  input  logic [MW-1:0] rssi_mono_th_i,
  input  logic [MW-1:0] rssi_st_th_i,
  input  logic [MW-1:0] snr_mono_th_i,
  input  logic [MW-1:0] snr_st_th_i,
  input  logic [MW-1:0] mpath_mono_th_i,
  input  logic [MW-1:0] mpath_st_th_i,
  input  logic [RW-1:0] rssi_att_i,
  input  logic [RW-1:0] rssi_rel_i,
  input  logic [RW-1:0] snr_att_i,
  input  logic [RW-1:0] snr_rel_i,
  input  logic [RW-1:0] mpath_att_i,
  input  logic [RW-1:0] mpath_rel_i,
  input  logic          ind_sel_i,
  output logic [AW-1:0] left_o,
  output logic [AW-1:0] right_o,
  output logic [BW-1:0] blend_o,
  output logic          stereo_ind_o
);
  import blend_pkg::*;

  logic [1:0]    rst_sync;
  logic          rst_int_n;
  logic [MW-1:0] met   [N_MET];
  logic [MW-1:0] mono  [N_MET];
  logic [MW-1:0] st    [N_MET];
  logic [RW-1:0] att   [N_MET];
  logic [RW-1:0] rel   [N_MET];
  logic [BW-1:0] tgt   [N_MET];
  logic [BW-1:0] tgt_min;
  logic          ind_hit, ind_d, ind_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  always_comb begin
    met[MET_RSSI]  = rssi_i;         met[MET_SNR]  = snr_i;         met[MET_MPATH]  = mpath_i;
    mono[MET_RSSI] = rssi_mono_th_i; mono[MET_SNR] = snr_mono_th_i; mono[MET_MPATH] = mpath_mono_th_i;
    st[MET_RSSI]   = rssi_st_th_i;   st[MET_SNR]   = snr_st_th_i;   st[MET_MPATH]   = mpath_st_th_i;
    att[MET_RSSI]  = rssi_att_i;     att[MET_SNR]  = snr_att_i;     att[MET_MPATH]  = mpath_att_i;
    rel[MET_RSSI]  = rssi_rel_i;     rel[MET_SNR]  = snr_rel_i;     rel[MET_MPATH]  = mpath_rel_i;
  end

  for (genvar g = 0; g < int'(N_MET); g++) begin : g_tgt
    blend_target #(.MW(MW), .BW(BW)) u_tgt (
      .metric_i(met[g]), .mono_th_i(mono[g]), .st_th_i(st[g]), .target_o(tgt[g])
    );
  end

  blend_slew #(.N(N_MET), .BW(BW), .RW(RW)) u_slew (
    .clk(clk), .rst_n(rst_int_n), .tick_i(tick_i),
    .tgt_i(tgt), .att_i(att), .rel_i(rel),
    .tgt_min_o(tgt_min), .blend_o(blend_o)
  );

  audio_matrix #(.AW(AW), .BW(BW)) u_mat (
    .clk(clk), .rst_n(rst_int_n), .tick_i(tick_i), .blend_i(blend_o),
    .sum_i(sum_i), .diff_i(diff_i), .left_o(left_o), .right_o(right_o)
  );

  always_comb begin
    if (ind_sel_i)
      ind_hit = (sep_i > MW'(IND_SEP_HI)) && (rssi_i > MW'(IND_RSSI_HI));
    else
      ind_hit = (sep_i > MW'(IND_SEP_LO)) && (rssi_i > MW'(IND_RSSI_LO));
    ind_d = tick_i ? ind_hit : ind_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ind_q <= 1'b0;
    else            ind_q <= ind_d;
  end
  assign stereo_ind_o = ind_q;
endmodule

// File: rtl/stereo_blend_chk.sv
module stereo_blend_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned MW = 7,
  parameter int unsigned BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_i,
  input logic          ind_sel_i,
  input logic [MW-1:0] rssi_i,
  input logic [MW-1:0] sep_i,
  input logic [BW-1:0] tgt_min,
  input logic [BW-1:0] blend_o,
  input logic [AW-1:0] left_o,
  input logic [AW-1:0] right_o,
  input logic          stereo_ind_o
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_state_chk: assert (blend_o == '0 && left_o == '0 && right_o == '0 && !stereo_ind_o);
    end
  end

  // R9
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> ($stable(blend_o) && $stable(left_o) && $stable(right_o) && $stable(stereo_ind_o)));

  // R8
  no_overshoot_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && blend_o <= tgt_min) |=> (blend_o <= $past(tgt_min) && blend_o >= $past(blend_o)));

  // R8
  no_overshoot_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && blend_o >= tgt_min) |=> (blend_o >= $past(tgt_min) && blend_o <= $past(blend_o)));

  // R10
  indicator_low_crit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !ind_sel_i && sep_i > MW'(6) && rssi_i > MW'(20)) |=> stereo_ind_o);

  // R10
  indicator_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && rssi_i <= MW'(20)) |=> !stereo_ind_o);
endmodule

bind stereo_blend_ctrl stereo_blend_chk #(.AW(AW), .MW(MW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ind_sel_i(ind_sel_i),
  .rssi_i(rssi_i), .sep_i(sep_i), .tgt_min(tgt_min), .blend_o(blend_o),
  .left_o(left_o), .right_o(right_o), .stereo_ind_o(stereo_ind_o)
);

// File: tb/stereo_blend_ctrl_test.sv
module stereo_blend_ctrl_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic tick;
  logic [15:0] sum, diff;
  logic [6:0] rssi, snr, mp, sep;
  logic [6:0] r_mo, r_st, s_mo, s_st, m_mo, m_st;
  logic [7:0] r_at, r_rl, s_at, s_rl, m_at, m_rl;
  logic ind_sel;
  logic [15:0] left, right;
  logic [7:0] blend;
  logic ind;

  int checks = 0;
  int errors = 0;
  int mb = 0;
  int exp_l = 0, exp_r = 0, exp_i = 0;

  always #(PERIOD/2) clk = ~clk;

  stereo_blend_ctrl uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .sum_i(sum), .diff_i(diff),
    .rssi_i(rssi), .snr_i(snr), .mpath_i(mp), .sep_i(sep),
    .rssi_mono_th_i(r_mo), .rssi_st_th_i(r_st), .snr_mono_th_i(s_mo), .snr_st_th_i(s_st),
    .mpath_mono_th_i(m_mo), .mpath_st_th_i(m_st),
    .rssi_att_i(r_at), .rssi_rel_i(r_rl), .snr_att_i(s_at), .snr_rel_i(s_rl),
    .mpath_att_i(m_at), .mpath_rel_i(m_rl), .ind_sel_i(ind_sel),
    .left_o(left), .right_o(right), .blend_o(blend), .stereo_ind_o(ind)
  );

  function automatic int tgt(int m, int mo, int st);
    if (mo == 127) return 0;
    if (st == 0) return 255;
    if (m < mo) return 0;
    if (m >= st) return 255;
    return ((m - mo) * 255) / (st - mo);
  endfunction

  function automatic int sat(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one update strobe, expected values from the requirements
  task automatic step(string tag);
    int t0, t1, t2, t, at, rl, d, sc, gap;
    t0 = tgt(rssi, r_mo, r_st); t1 = tgt(snr, s_mo, s_st); t2 = tgt(mp, m_mo, m_st);
    t = t0; at = r_at; rl = r_rl;
    if (t1 < t) begin t = t1; at = s_at; rl = s_rl; end
    if (t2 < t) begin t = t2; at = m_at; rl = m_rl; end
    d  = $signed(diff);
    sc = (mb == 255) ? d : ((d * mb) >>> 8);
    exp_l = sat($signed(sum) + sc);
    exp_r = sat($signed(sum) - sc);
    exp_i = ind_sel ? int'(sep > 12 && rssi > 28) : int'(sep > 6 && rssi > 20);
    if (mb > t) begin gap = mb - t; mb = (at >= gap) ? t : mb - at; end
    else begin gap = t - mb; mb = (rl >= gap) ? t : mb + rl; end
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    check(tag, "blend", int'(blend), mb);
    check(tag, "left", $signed(left), exp_l);
    check(tag, "right", $signed(right), exp_r);
    check(tag, "ind", int'(ind), exp_i);
  endtask

  task automatic t_reset();
    check("R1", "blend", int'(blend), 0);
    check("R1", "left", int'(left), 0);
    check("R1", "right", int'(right), 0);
    check("R1", "ind", int'(ind), 0);
  endtask

  task automatic t_release();
    rssi = 127; snr = 127; mp = 127;
    r_rl = 64; s_rl = 255; m_rl = 255;
    for (int i = 0; i < 5; i++) step("R8_release_R5");
    check("R5", "final", int'(blend), 255);
  endtask

  task automatic t_attack();
    rssi = 3; r_at = 100;
    for (int i = 0; i < 4; i++) step("R8_attack_R4");
    check("R4", "final", int'(blend), 0);
  endtask

  task automatic t_prop();
    r_at = 255; r_rl = 255; s_at = 255; s_rl = 255; m_at = 20; m_rl = 255;
    rssi = 28; snr = 127; mp = 127;
    step("R6_single");
    check("R6", "value", int'(blend), (20 * 255) / 41);
    snr = 25; step("R6_min");
    mp = 10;
    for (int i = 0; i < 5; i++) step("R8_governing");
    check("R6", "mp_value", int'(blend), (5 * 255) / 25);
  endtask

  task automatic t_forced();
    rssi = 0; snr = 127; mp = 127; m_at = 255;
    r_st = 0; step("R7_force_stereo");
    check("R7", "stereo", int'(blend), 255);
    r_mo = 127; step("R7_force_mono");
    check("R7", "mono", int'(blend), 0);
    r_mo = 8; r_st = 49;
  endtask

  task automatic t_audio();
    rssi = 127; r_rl = 128; sum = 16'sd1000; diff = 16'sd200;
    step("R2_mono");
    diff = -16'sd201; r_rl = 255;
    step("R2_half");
    sum = 16'sd1000; diff = 16'sd200; step("R2_full");
    sum = 16'sd30000; diff = 16'sd10000; step("R3_pos");
    sum = -16'sd30000; step("R3_neg");
    sum = -16'sd20000; diff = -16'sd20000; step("R3_both");
  endtask

  task automatic t_hold();
    int bl, ll, rr, ii;
    bl = blend; ll = left; rr = right; ii = ind;
    sum = 16'sd5; diff = 16'sd7; rssi = 0; sep = 100;
    repeat (6) @(negedge clk);
    check("R9", "blend", int'(blend), bl);
    check("R9", "left", int'(left), ll);
    check("R9", "right", int'(right), rr);
    check("R9", "ind", int'(ind), ii);
  endtask

  task automatic t_ind();
    rssi = 21; sep = 7; ind_sel = 1'b0; step("R10_lo_on");
    sep = 6; step("R10_lo_sep");
    rssi = 20; sep = 50; step("R10_lo_rssi");
    ind_sel = 1'b1; rssi = 30; sep = 12; step("R10_hi_sep");
    rssi = 29; sep = 13; step("R10_hi_on");
    rssi = 28; step("R10_hi_rssi");
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; sum = '0; diff = '0;
    rssi = '0; snr = '0; mp = '0; sep = '0; ind_sel = 1'b0;
    r_mo = 8; r_st = 49; s_mo = 10; s_st = 40; m_mo = 5; m_st = 30;
    r_at = 255; r_rl = 255; s_at = 255; s_rl = 255; m_at = 255; m_rl = 255;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_release();
    t_attack();
    t_prop();
    t_forced();
    t_audio();
    t_hold();
    t_ind();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule